// File: doc/BRIEF.md
# Burst Address-Phase Sequencer

This block forms the address phase of a simple bus master, for example a copy engine that moves data in bursts. It takes one burst request at a time: a start address, a transfer size, a beat count and an incrementing or wrapping mode. It then presents the transfer type, address, burst code and size for each beat. The first beat of a request is marked NONSEQ, each later beat is marked SEQ, and IDLE appears only when no request is in progress. The address moves on by the transfer size after every accepted beat. In wrapping mode it stays inside an aligned window.

The master's data source can signal that it is not ready. If that happens while a burst has beats still to send, the sequencer issues BUSY. It keeps its beat position and the pending address until the source is ready again, then resumes with SEQ. It never falls back to IDLE and never reissues NONSEQ in that case. Slave wait states, shown by the ready input being low, freeze every address-phase output. A new request can be accepted in the same cycle that the final beat is accepted, so two bursts can follow each other with no IDLE between them.

Top module: `burst_xfer_gen`

## Requirements
- R1: An asynchronous low reset forces the transfer type to IDLE (code 00) and the address to 0. After reset, `req_ready_o` is high whenever `hready_i` is high.
- R2: A request is taken when `req_valid_i` and `req_ready_o` are both high. In the next cycle the transfer type is NONSEQ (code 10) and the address is the requested start address.
- R3: A burst carries `req_len_i`+1 beats. Every beat after the first is SEQ (code 11), and its address is the previous one plus 2^size bytes. The size field uses 0 for a byte, 1 for a halfword and 2 for a word.
- R4: In wrapping mode (`req_wrap_i`=1), the address stays inside the aligned window of (len+1)·2^size bytes and wraps to the window base.
- R5: If the stall input is high when a beat that is not the last one is accepted, the next cycle shows BUSY (code 01). The address is the next pending beat's address, and it holds while the stall stays high.
- R6: From BUSY, once the stall input is low and `hready_i` is high, the next cycle is SEQ at the held address. The remaining beat count is kept. Neither IDLE nor NONSEQ appears before the final beat is accepted.
- R7: While `hready_i` is low, the transfer type, address, burst code and size hold their values, and no request is taken.
- R8: The stall input has no effect when the sequencer is idle or when the final beat of a burst is being accepted.
- R9: `req_ready_o` is high only when `hready_i` is high and the sequencer is either idle or presenting its final beat. A request taken at the final beat is shown as NONSEQ in the very next cycle.
- R10: A request with len 0 (a single transfer) produces exactly one NONSEQ and then IDLE.
- R11: The burst code is set from the request as follows: 000 for a single transfer; 010, 100 and 110 for wrapping 4, 8 and 16 beats; 011, 101 and 111 for incrementing 4, 8 and 16 beats; 001 for any other incrementing length.
- R12: After the final beat is accepted with no new request waiting, the transfer type returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Burst request present |
| req_ready_o | output | 1 | Request is taken in this cycle if valid |
| req_addr_i | input | ADDR_W | Start address |
| req_wrap_i | input | 1 | 1 = wrapping, 0 = incrementing |
| req_size_i | input | 3 | Transfer size, log2 of bytes |
| req_len_i | input | LEN_W | Beat count minus one |
| src_stall_i | input | 1 | Data source not ready |
| hready_i | input | 1 | Bus ready; low means wait state |
| htrans_o | output | 2 | Transfer type |
| haddr_o | output | ADDR_W | Beat address |
| hburst_o | output | 3 | Burst code |
| hsize_o | output | 3 | Transfer size |

## Verification
The assertions assume that `hready_i` is a proper bus ready. They also assume that a wrapping request uses 4, 8 or 16 beats with a start address aligned to the size, because the window rule only holds for those lengths. The stimulus table and the directed tests only issue wrapping requests of 4 or 8 beats with aligned word or halfword addresses. They raise the stall input in the states R8 says it must be ignored, and they drop `hready_i` during IDLE, NONSEQ, SEQ and BUSY, so every hold rule is exercised under the conditions the assertions rely on.

// File: rtl/bxg_pkg.sv
package bxg_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_BEAT,
    ST_PAUSE
  } gen_st_e;
endpackage

// File: rtl/bxg_burst_enc.sv
module bxg_burst_enc #(
  parameter int LEN_W = 4
) (
  input  logic             wrap_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [2:0]       burst_o
);
  logic [LEN_W:0] beats;

  assign beats = {1'b0, len_i} + (LEN_W+1)'(1);

  always_comb begin
    if (len_i == '0)                      burst_o = 3'b000;
    else if (beats == (LEN_W+1)'(4))      burst_o = wrap_i ? 3'b010 : 3'b011;
    else if (beats == (LEN_W+1)'(8))      burst_o = wrap_i ? 3'b100 : 3'b101;
    else if (beats == (LEN_W+1)'(16))     burst_o = wrap_i ? 3'b110 : 3'b111;
    else                                  burst_o = 3'b001;
  end
endmodule

// File: rtl/bxg_addr_step.sv
module bxg_addr_step #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic              wrap_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] incr, span, mask, sum;

  assign incr = ADDR_W'(1) << size_i;
  assign span = (ADDR_W'(len_i) + ADDR_W'(1)) << size_i;
  assign mask = span - ADDR_W'(1);
  assign sum  = addr_i + incr;
  // wrap keeps the window base, lets only the low bits roll over
  assign next_o = wrap_i ? ((addr_i & ~mask) | (sum & mask)) : sum;
endmodule

// File: rtl/bxg_beat_fsm.sv
module bxg_beat_fsm
  import bxg_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             hready_i,
  input  logic             stall_i,
  output logic             free_o,
  output logic             start_o,
  output logic             adv_o,
  output htrans_e          trans_o
);
  gen_st_e          st_q, st_d;
  logic [LEN_W-1:0] rem_q;
  logic             active, last, accept;

  assign active  = (st_q == ST_FIRST) || (st_q == ST_BEAT);
  assign last    = (rem_q == '0);
  assign accept  = active && hready_i;
  assign adv_o   = accept && !last;
  assign free_o  = hready_i && ((st_q == ST_IDLE) || (active && last));
  assign start_o = req_valid_i && free_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_o) st_d = ST_FIRST;
      ST_FIRST,
      ST_BEAT: begin
        if (accept) begin
          if (last)         st_d = start_o ? ST_FIRST : ST_IDLE;
          else if (stall_i) st_d = ST_PAUSE;
          else              st_d = ST_BEAT;
        end
      end
      ST_PAUSE: if (hready_i && !stall_i) st_d = ST_BEAT;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_q)
      ST_FIRST: trans_o = TR_NONSEQ;
      ST_BEAT:  trans_o = TR_SEQ;
      ST_PAUSE: trans_o = TR_BUSY;
      default:  trans_o = TR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
    end else begin
      st_q <= st_d;
      if (start_o)    rem_q <= len_i;
      else if (adv_o) rem_q <= rem_q - LEN_W'(1);
    end
  end

  AST_BUSY_EXITS_TO_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trans_o == TR_BUSY |=> (trans_o == TR_BUSY || trans_o == TR_SEQ)); // R6
  AST_BUSY_INSIDE_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trans_o == TR_BUSY |-> $past(trans_o) != TR_IDLE); // R8
  AST_SEQ_HAS_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trans_o == TR_SEQ |-> $past(trans_o) != TR_IDLE); // R3
  AST_BUSY_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trans_o == TR_BUSY |=> $stable(rem_q)); // R6
  AST_FREE_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trans_o == TR_BUSY) |-> !free_o); // R9
endmodule

// File: rtl/burst_xfer_gen.sv
module burst_xfer_gen
  import bxg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wrap_i,
  input  logic [2:0]        req_size_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              src_stall_i,
  input  logic              hready_i,
  output logic [1:0]        htrans_o,
  output logic [ADDR_W-1:0] haddr_o,
  output logic [2:0]        hburst_o,
  output logic [2:0]        hsize_o
);
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic [2:0]        size_q, burst_q, burst_req;
  logic              wrap_q;
  logic [LEN_W-1:0]  len_q;
  logic              start, adv, free;
  htrans_e           trans;

  bxg_beat_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .len_i       (req_len_i),
    .hready_i    (hready_i),
    .stall_i     (src_stall_i),
    .free_o      (free),
    .start_o     (start),
    .adv_o       (adv),
    .trans_o     (trans)
  );

  bxg_addr_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_step (
    .addr_i (addr_q),
    .size_i (size_q),
    .wrap_i (wrap_q),
    .len_i  (len_q),
    .next_o (addr_nx)
  );

  bxg_burst_enc #(.LEN_W(LEN_W)) u_enc (
    .wrap_i  (req_wrap_i),
    .len_i   (req_len_i),
    .burst_o (burst_req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      size_q  <= '0;
      burst_q <= '0;
      wrap_q  <= 1'b0;
      len_q   <= '0;
    end else if (start) begin
      addr_q  <= req_addr_i;
      size_q  <= req_size_i;
      burst_q <= burst_req;
      wrap_q  <= req_wrap_i;
      len_q   <= req_len_i;
    end else if (adv) begin
      addr_q  <= addr_nx;
    end
  end

  assign req_ready_o = free;
  assign htrans_o    = trans;
  assign haddr_o     = addr_q;
  assign hburst_o    = burst_q;
  assign hsize_o     = size_q;

  AST_HOLD_ON_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_i |=> ($stable(htrans_o) && $stable(haddr_o) && $stable(hburst_o) && $stable(hsize_o))); // R7
  AST_BUSY_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == TR_BUSY && $past(htrans_o) == TR_BUSY) |-> $stable(haddr_o)); // R5
  AST_RESUME_SAME_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == TR_SEQ && $past(htrans_o) == TR_BUSY) |-> $stable(haddr_o)); // R6
  AST_HEAD_AT_REQ_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (htrans_o == TR_NONSEQ && haddr_o == $past(req_addr_i))); // R2
endmodule

// File: tb/burst_xfer_gen_test.sv
module burst_xfer_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS      = 17;

  typedef struct packed {
    logic        vld;
    logic        wrap;
    logic [2:0]  size;
    logic [3:0]  len;
    logic [31:0] addr;
    logic        stall;
    logic        hrdy;
    logic        erdy;
    logic [1:0]  etr;
    logic [31:0] eaddr;
  } row_t;

  function automatic row_t mk(logic v, logic w, logic [2:0] s, logic [3:0] l,
                              logic [31:0] a, logic st, logic hr, logic er,
                              logic [1:0] et, logic [31:0] ea);
    row_t r;
    r.vld = v; r.wrap = w; r.size = s; r.len = l; r.addr = a;
    r.stall = st; r.hrdy = hr; r.erdy = er; r.etr = et; r.eaddr = ea;
    return r;
  endfunction

  // transfer codes: 00 idle, 01 busy, 10 nonseq, 11 seq
  localparam row_t TBL [NROWS] = '{
    mk(1, 0, 2, 3, 32'h100, 0, 1, 1, 2'b10, 32'h100), // R2 incr4 head
    mk(0, 0, 0, 0, 32'h0,   0, 1, 0, 2'b11, 32'h104), // R3
    mk(0, 0, 0, 0, 32'h0,   1, 1, 0, 2'b01, 32'h108), // R5 stall -> busy, next addr
    mk(0, 0, 0, 0, 32'h0,   1, 1, 0, 2'b01, 32'h108), // R5 held
    mk(0, 0, 0, 0, 32'h0,   0, 0, 0, 2'b01, 32'h108), // R7 wait holds busy
    mk(0, 0, 0, 0, 32'h0,   0, 1, 0, 2'b11, 32'h108), // R6 resume seq
    mk(0, 0, 0, 0, 32'h0,   0, 0, 0, 2'b11, 32'h108), // R7 wait holds seq
    mk(0, 0, 0, 0, 32'h0,   0, 1, 0, 2'b11, 32'h10C), // R3 final beat
    mk(1, 0, 0, 0, 32'h200, 1, 1, 1, 2'b10, 32'h200), // R9 R8 back-to-back single
    mk(0, 0, 0, 0, 32'h0,   1, 1, 1, 2'b00, 32'h0),   // R10 R8 single ends idle
    mk(1, 1, 2, 3, 32'h38,  0, 0, 0, 2'b00, 32'h0),   // R7 no take during wait
    mk(1, 1, 2, 3, 32'h38,  0, 1, 1, 2'b10, 32'h38),  // R2 wrap4 head
    mk(0, 0, 0, 0, 32'h0,   0, 1, 0, 2'b11, 32'h3C),  // R4
    mk(0, 0, 0, 0, 32'h0,   0, 1, 0, 2'b11, 32'h30),  // R4 wrapped
    mk(0, 0, 0, 0, 32'h0,   0, 1, 0, 2'b11, 32'h34),  // R4
    mk(0, 0, 0, 0, 32'h0,   0, 1, 1, 2'b00, 32'h0),   // R12 idle after end
    mk(0, 0, 0, 0, 32'h0,   1, 1, 1, 2'b00, 32'h0)    // R8 stall while idle
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic        req_wrap_i = 1'b0;
  logic [2:0]  req_size_i = '0;
  logic [3:0]  req_len_i = '0;
  logic        src_stall_i = 1'b0;
  logic        hready_i = 1'b0;
  logic [1:0]  htrans_o;
  logic [31:0] haddr_o;
  logic [2:0]  hburst_o;
  logic [2:0]  hsize_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst_xfer_gen #(.ADDR_W(32), .LEN_W(4)) uut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_wrap_i,
    .req_size_i, .req_len_i, .src_stall_i, .hready_i, .htrans_o, .haddr_o,
    .hburst_o, .hsize_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(logic v, logic w, logic [2:0] s, logic [3:0] l,
                     logic [31:0] a, logic st, logic hr);
    req_valid_i = v; req_wrap_i = w; req_size_i = s; req_len_i = l;
    req_addr_i = a; src_stall_i = st; hready_i = hr;
  endtask

  task automatic tick;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #1;
    chk("R1 reset trans", 32'(htrans_o), 32'h0);
    chk("R1 reset addr", haddr_o, 32'h0);
    tick(); tick();
    rst_ni = 1'b1;
    put(0, 0, 0, 0, 0, 0, 1);
    #1;
    chk("R1 ready after reset", 32'(req_ready_o), 32'h1);
    tick();

    foreach (TBL[i]) begin
      put(TBL[i].vld, TBL[i].wrap, TBL[i].size, TBL[i].len, TBL[i].addr,
          TBL[i].stall, TBL[i].hrdy);
      #1;
      chk($sformatf("row %0d ready", i), 32'(req_ready_o), 32'(TBL[i].erdy));
      tick();
      chk($sformatf("row %0d trans", i), 32'(htrans_o), 32'(TBL[i].etr));
      if (TBL[i].etr != 2'b00)
        chk($sformatf("row %0d addr", i), haddr_o, TBL[i].eaddr);
    end

    // R11 incr4 word codes
    put(1, 0, 2, 3, 32'h400, 0, 1); tick();
    chk("R11 incr4 burst", 32'(hburst_o), 32'h3);
    chk("R3 word size", 32'(hsize_o), 32'h2);
    put(0, 0, 0, 0, 0, 0, 1); tick(); tick(); tick(); tick();
    chk("R12 idle after incr4", 32'(htrans_o), 32'h0);

    // R4 wrap8 halfword
    put(1, 1, 1, 7, 32'h1C, 0, 1); tick();
    chk("R11 wrap8 burst", 32'(hburst_o), 32'h4);
    chk("R2 wrap8 head", haddr_o, 32'h1C);
    put(0, 0, 0, 0, 0, 0, 1); tick();
    chk("R4 wrap8 beat1", haddr_o, 32'h1E);
    tick();
    chk("R4 wrap8 beat2 wraps", haddr_o, 32'h10);
    chk("R4 wrap8 still seq", 32'(htrans_o), 32'h3);

    // R1 asynchronous reset mid-burst
    #2; rst_ni = 1'b0; #1;
    chk("R1 async reset trans", 32'(htrans_o), 32'h0);
    tick(); rst_ni = 1'b1; #1;

    // R10 single code
    put(1, 0, 0, 0, 32'h77, 0, 1); tick();
    chk("R11 single burst", 32'(hburst_o), 32'h0);
    chk("R10 single head", 32'(htrans_o), 32'h2);
    put(0, 0, 0, 0, 0, 0, 1); tick();
    chk("R10 single ends", 32'(htrans_o), 32'h0);

    // R11 odd length incrementing
    put(1, 0, 0, 5, 32'h80, 0, 1); tick();
    chk("R11 incr undefined length", 32'(hburst_o), 32'h1);
    put(0, 0, 0, 0, 0, 0, 0); tick();
    chk("R7 head held on wait", 32'(htrans_o), 32'h2);
    chk("R7 burst held on wait", 32'(hburst_o), 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule